// File: doc/BRIEF.md
# Reuse-Directed Operand Cache for a Two-Bank Register File

This block sits between the operand-read stage of one sub-core and its two-bank register file. It keeps a small set of recently read source operands so that a later instruction reading the same value in the same operand position can skip the bank read. There are six slots, one per bank and operand position. Position means the first, second or third source operand of an instruction. The compiler decides what is kept: each operand read carries a reuse flag, and only reads with that flag set leave their value behind.

Each request carries a warp number, a register number, an operand position, a pair flag and a reuse flag. A single register lives in the bank picked by its lowest bit. A paired operand covers an even register and the odd register after it, so it touches both banks at once. Each half is looked up and cached in the slot of its own bank.

On a miss the block drives a read to the bank. The bank answers one cycle later. The response appears in the cycle after the request and carries, for each half, either the cached value or the bank data.

Each slot is a three-state machine with these states:
- SLOT_EMPTY: the slot holds nothing usable.
- SLOT_FILL: the tag is written and the slot waits for the bank data.
- SLOT_HELD: the slot holds a valid tag and value.

The slot moves between them as follows:
- A read with reuse that misses moves the slot to SLOT_FILL.
- SLOT_FILL moves to SLOT_HELD on the next cycle, capturing the bank data.
- A read with reuse that hits keeps the slot in SLOT_HELD.
- A read without reuse, hit or miss, moves the slot to SLOT_EMPTY.
- A warp-done pulse moves every slot to SLOT_EMPTY.
- With no access, a slot stays where it is, except that SLOT_FILL advances.

Top module: `opc_top`

## Requirements
- R1: After reset every slot is empty, so the first request of any kind misses. With no request, `bank_rd_en` is 00 and `rsp_valid` is 0.
- R2: Bank selection and address.
  - A single operand uses bank 0 when bit 0 of `req_reg` is 0 and bank 1 when it is 1.
  - A bank read drives `bank_rd_en` bit b for bank b.
  - The bank address is `{req_warp, req_reg[REG_W-1:1]}`.
- R3: A half that misses takes its value from the bank data returned in the cycle after the request, and its `rsp_hit` bit is 0.
- R4: A read that misses without reuse stores nothing; the same read repeated misses again.
- R5: A hit needs the stored warp, register and operand position all to equal the request. A different position or a different warp misses.
- R6: Any read to a bank and position slot leaves it empty afterwards, including a read that hits, unless that read has reuse set. A reuse read that hits keeps the value.
- R7: A hit returns the cached value and issues no read to that bank.
- R8: Paired operands.
  - A paired read of register r sends r with bit 0 cleared to bank 0 and that register plus one to bank 1.
  - The low half appears in `rsp_data[DATA_W-1:0]` and the high half in `rsp_data[2*DATA_W-1:DATA_W]`, with `rsp_hit[0]` for low and `rsp_hit[1]` for high.
  - Each half hits or misses on its own.
  - For a single read, the high half and `rsp_hit[1]` are 0.
- R9: A one-cycle `warp_done` pulse empties all slots.
- R10: A reuse read that misses in an occupied slot replaces the old tag and value, so the older register then misses.
- R11: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Operand read request |
| req_warp | input | WARP_W | Warp number |
| req_reg | input | REG_W | Register number |
| req_pos | input | 2 | Operand position, 0 to 2 |
| req_pair | input | 1 | Operand covers an even and odd register pair |
| req_reuse | input | 1 | Keep this operand in the cache |
| warp_done | input | 1 | Empty all slots |
| bank_rd_en | output | 2 | Read strobe per bank |
| bank0_rd_addr | output | WARP_W+REG_W-1 | Bank 0 row address |
| bank1_rd_addr | output | WARP_W+REG_W-1 | Bank 1 row address |
| bank0_rdata | input | DATA_W | Bank 0 data, one cycle after the strobe |
| bank1_rdata | input | DATA_W | Bank 1 data, one cycle after the strobe |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 2 | Hit per half, bit 0 low half |
| rsp_data | output | 2*DATA_W | Operand data, low half in the low bits |

## Verification
The bench aims at invalidation.

- A hit without reuse must still empty its slot; a design that only clears on a miss would return a stale value to a third read.
- A read from another warp must empty the slot without hitting; a design that ignored position or warp in the compare would hit it.
- Paired reads where one half hits and the other misses catch a design that treats the pair as one unit.
- A replaced tag must miss afterwards.
- A warp-done pulse must empty everything.

The bank model changes its data on every request, so a value served from the cache instead of the bank, or the other way round, shows up in the data.

// File: rtl/opc_pkg.sv
package opc_pkg;
    localparam int NUM_BANKS = 2;
    localparam int NUM_POS   = 3;

    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_FILL  = 2'd1,
        SLOT_HELD  = 2'd2
    } slot_state_e;
endpackage

// File: rtl/opc_route.sv
module opc_route
    import opc_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic                               req_valid,
    input  logic [REG_W-1:0]                   req_reg,
    input  logic                               req_pair,
    output logic [NUM_BANKS-1:0]               bank_acc,
    output logic [NUM_BANKS-1:0][REG_W-1:0]    bank_reg
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic own_bank;

        always_comb begin
            own_bank    = (req_reg[0] == b[0]);
            bank_acc[b] = req_valid && (req_pair || own_bank);
            if (req_pair) begin
                bank_reg[b] = {req_reg[REG_W-1:1], b[0]};
            end else begin
                bank_reg[b] = req_reg;
            end
        end
    end
endmodule

// File: rtl/opc_slot.sv
module opc_slot
    import opc_pkg::*;
#(
    parameter int WARP_W = 5,
    parameter int REG_W  = 8,
    parameter int DATA_W = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              acc,
    input  logic [WARP_W-1:0] acc_warp,
    input  logic [REG_W-1:0]  acc_reg,
    input  logic              reuse,
    input  logic [DATA_W-1:0] fill_data,
    output logic              hit,
    output logic [DATA_W-1:0] data_q
);
    slot_state_e       state_q;
    slot_state_e       state_d;
    logic [WARP_W-1:0] tag_warp_q;
    logic [REG_W-1:0]  tag_reg_q;
    logic              match;
    logic              load_tag;
    logic              load_data;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = SLOT_EMPTY;
        end else if (acc) begin
            if (!reuse) begin
                state_d = SLOT_EMPTY;
            end else if (match) begin
                state_d = SLOT_HELD;
            end else begin
                state_d = SLOT_FILL;
            end
        end else begin
            unique case (state_q)
                SLOT_EMPTY: state_d = SLOT_EMPTY;
                SLOT_FILL:  state_d = SLOT_HELD;
                SLOT_HELD:  state_d = SLOT_HELD;
                default:    state_d = SLOT_EMPTY;
            endcase
        end
    end

    // Outputs and register-load controls
    always_comb begin
        match = (state_q == SLOT_HELD) && (tag_warp_q == acc_warp) && (tag_reg_q == acc_reg);
        hit       = acc && match;
        load_tag  = !flush && acc && reuse && !match;
        load_data = !flush && !acc && (state_q == SLOT_FILL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_warp_q <= '0;
            tag_reg_q  <= '0;
        end else if (load_tag) begin
            tag_warp_q <= acc_warp;
            tag_reg_q  <= acc_reg;
        end
    end

    always_ff @(posedge clk) begin
        if (load_data) begin
            data_q <= fill_data;
        end
    end

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (state_q == SLOT_EMPTY));

    assert_plain_read_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !reuse) |=> (state_q == SLOT_EMPTY));

    assert_fill_needs_reuse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_FILL) |-> $past(acc && reuse && !flush));

    assert_held_value_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == SLOT_HELD) && $past(state_q == SLOT_HELD)) |-> $stable(data_q));
endmodule

// File: rtl/opc_resp.sv
module opc_resp
    import opc_pkg::*;
#(
    parameter int DATA_W = 1024
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic                              req_pair,
    input  logic                              lo_bank,
    input  logic [NUM_BANKS-1:0]              bank_hit,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0]  bank_cdata,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0]  bank_rdata,
    output logic                              rsp_valid,
    output logic [1:0]                        rsp_hit,
    output logic [2*DATA_W-1:0]               rsp_data
);
    logic                             valid_q;
    logic                             pair_q;
    logic                             lo_bank_q;
    logic [NUM_BANKS-1:0]             hit_q;
    logic [NUM_BANKS-1:0][DATA_W-1:0] cdata_q;
    logic                             lo_sel;
    logic [DATA_W-1:0]                lo_data;
    logic [DATA_W-1:0]                hi_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q   <= 1'b0;
            pair_q    <= 1'b0;
            lo_bank_q <= 1'b0;
            hit_q     <= '0;
        end else begin
            valid_q   <= req_valid;
            pair_q    <= req_pair;
            lo_bank_q <= lo_bank;
            hit_q     <= bank_hit;
        end
    end

    always_ff @(posedge clk) begin
        cdata_q <= bank_cdata;
    end

    always_comb begin
        lo_sel  = pair_q ? 1'b0 : lo_bank_q;
        lo_data = hit_q[lo_sel] ? cdata_q[lo_sel] : bank_rdata[lo_sel];
        hi_data = hit_q[1] ? cdata_q[1] : bank_rdata[1];
        rsp_valid = valid_q;
        rsp_hit   = '0;
        rsp_data  = '0;
        if (valid_q) begin
            rsp_hit[0]              = hit_q[lo_sel];
            rsp_data[DATA_W-1:0]    = lo_data;
            if (pair_q) begin
                rsp_hit[1]                  = hit_q[1];
                rsp_data[2*DATA_W-1:DATA_W] = hi_data;
            end
        end
    end

    assert_rsp_follows_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    assert_single_no_high_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !$past(req_pair)) |-> !rsp_hit[1]);
endmodule

// File: rtl/opc_top.sv
module opc_top
    import opc_pkg::*;
#(
    parameter int WARP_W = 5,
    parameter int REG_W  = 8,
    parameter int DATA_W = 1024,
    localparam int ADDR_W = WARP_W + REG_W - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [WARP_W-1:0]   req_warp,
    input  logic [REG_W-1:0]    req_reg,
    input  logic [1:0]          req_pos,
    input  logic                req_pair,
    input  logic                req_reuse,
    input  logic                warp_done,
    output logic [1:0]          bank_rd_en,
    output logic [ADDR_W-1:0]   bank0_rd_addr,
    output logic [ADDR_W-1:0]   bank1_rd_addr,
    input  logic [DATA_W-1:0]   bank0_rdata,
    input  logic [DATA_W-1:0]   bank1_rdata,
    output logic                rsp_valid,
    output logic [1:0]          rsp_hit,
    output logic [2*DATA_W-1:0] rsp_data
);
    logic [NUM_BANKS-1:0]               bank_acc;
    logic [NUM_BANKS-1:0][REG_W-1:0]    bank_reg;
    logic [NUM_BANKS-1:0][NUM_POS-1:0]  slot_hit;
    logic [DATA_W-1:0]                  slot_data [NUM_BANKS][NUM_POS];
    logic [NUM_BANKS-1:0]               bank_hit;
    logic [NUM_BANKS-1:0][DATA_W-1:0]   bank_cdata;
    logic [NUM_BANKS-1:0][DATA_W-1:0]   bank_rdata;

    assign bank_rdata[0] = bank0_rdata;
    assign bank_rdata[1] = bank1_rdata;

    opc_route #(.REG_W(REG_W)) u_route (
        .req_valid (req_valid),
        .req_reg   (req_reg),
        .req_pair  (req_pair),
        .bank_acc  (bank_acc),
        .bank_reg  (bank_reg)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar p = 0; p < NUM_POS; p++) begin : g_pos
            logic pos_acc;
            assign pos_acc = bank_acc[b] && (req_pos == p[1:0]);

            opc_slot #(.WARP_W(WARP_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .flush     (warp_done),
                .acc       (pos_acc),
                .acc_warp  (req_warp),
                .acc_reg   (bank_reg[b]),
                .reuse     (req_reuse),
                .fill_data (bank_rdata[b]),
                .hit       (slot_hit[b][p]),
                .data_q    (slot_data[b][p])
            );
        end

        always_comb begin
            bank_hit[b]   = |slot_hit[b];
            bank_cdata[b] = '0;
            for (int p = 0; p < NUM_POS; p++) begin
                if (slot_hit[b][p]) begin
                    bank_cdata[b] = slot_data[b][p];
                end
            end
            bank_rd_en[b] = bank_acc[b] && !bank_hit[b];
        end
    end

    assign bank0_rd_addr = {req_warp, bank_reg[0][REG_W-1:1]};
    assign bank1_rd_addr = {req_warp, bank_reg[1][REG_W-1:1]};

    opc_resp #(.DATA_W(DATA_W)) u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_pair   (req_pair),
        .lo_bank    (req_reg[0]),
        .bank_hit   (bank_hit),
        .bank_cdata (bank_cdata),
        .bank_rdata (bank_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_hit    (rsp_hit),
        .rsp_data   (rsp_data)
    );

    assert_no_read_on_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit[0] && $past(req_pair)) |-> !$past(bank_rd_en[0]));
endmodule

// File: tb/tb_opc_top.sv
`timescale 1ns/1ps
module tb_opc_top;
    localparam int WARP_W = 3;
    localparam int REG_W  = 8;
    localparam int DATA_W = 32;
    localparam int ADDR_W = WARP_W + REG_W - 1;
    localparam int NV     = 20;

    // fields: warp(3) reg(8) pos(2) pair(1) reuse(1) exp_hit(2) exp_epoch_lo(8) exp_epoch_hi(8)
    localparam logic [32:0] VEC [NV] = '{
        {3'd1, 8'd4,  2'd0, 1'b0, 1'b1, 2'b00, 8'd0,  8'd0},  // R4 allocate
        {3'd1, 8'd4,  2'd0, 1'b0, 1'b0, 2'b01, 8'd0,  8'd0},  // R7 hit
        {3'd1, 8'd4,  2'd0, 1'b0, 1'b0, 2'b00, 8'd2,  8'd0},  // R6 hit cleared it
        {3'd1, 8'd4,  2'd1, 1'b0, 1'b1, 2'b00, 8'd3,  8'd0},  // R5 other position
        {3'd1, 8'd4,  2'd0, 1'b0, 1'b1, 2'b00, 8'd4,  8'd0},  // R5 position empty
        {3'd2, 8'd4,  2'd1, 1'b0, 1'b0, 2'b00, 8'd5,  8'd0},  // R5 other warp
        {3'd1, 8'd4,  2'd1, 1'b0, 1'b0, 2'b00, 8'd6,  8'd0},  // R6 foreign read cleared
        {3'd1, 8'd4,  2'd0, 1'b0, 1'b1, 2'b01, 8'd4,  8'd0},  // R6 reuse hit keeps
        {3'd1, 8'd4,  2'd0, 1'b0, 1'b0, 2'b01, 8'd4,  8'd0},  // R7 still held
        {3'd1, 8'd4,  2'd0, 1'b0, 1'b0, 2'b00, 8'd9,  8'd0},  // R6 third read misses
        {3'd1, 8'd7,  2'd2, 1'b0, 1'b0, 2'b00, 8'd10, 8'd0},  // R2 bank 1, R4 no store
        {3'd1, 8'd7,  2'd2, 1'b0, 1'b1, 2'b00, 8'd11, 8'd0},  // R4 miss again
        {3'd1, 8'd7,  2'd2, 1'b0, 1'b1, 2'b01, 8'd11, 8'd0},  // R7
        {3'd1, 8'd9,  2'd2, 1'b0, 1'b1, 2'b00, 8'd13, 8'd0},  // R10 replace
        {3'd1, 8'd7,  2'd2, 1'b0, 1'b0, 2'b00, 8'd14, 8'd0},  // R10 old misses
        {3'd3, 8'd10, 2'd1, 1'b1, 1'b1, 2'b00, 8'd15, 8'd15}, // R8 pair allocate
        {3'd3, 8'd11, 2'd1, 1'b0, 1'b0, 2'b01, 8'd15, 8'd0},  // R8 half hits alone
        {3'd3, 8'd10, 2'd1, 1'b1, 1'b1, 2'b01, 8'd15, 8'd17}, // R8 split hit
        {3'd3, 8'd10, 2'd1, 1'b1, 1'b0, 2'b11, 8'd15, 8'd17}, // R8 both hit
        {3'd3, 8'd10, 2'd1, 1'b1, 1'b1, 2'b00, 8'd19, 8'd19}  // R6 both cleared
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic [WARP_W-1:0]   req_warp = '0;
    logic [REG_W-1:0]    req_reg = '0;
    logic [1:0]          req_pos = '0;
    logic                req_pair = 1'b0;
    logic                req_reuse = 1'b0;
    logic                warp_done = 1'b0;
    logic [1:0]          bank_rd_en;
    logic [ADDR_W-1:0]   bank0_rd_addr;
    logic [ADDR_W-1:0]   bank1_rd_addr;
    logic [DATA_W-1:0]   bank0_rdata = '0;
    logic [DATA_W-1:0]   bank1_rdata = '0;
    logic                rsp_valid;
    logic [1:0]          rsp_hit;
    logic [2*DATA_W-1:0] rsp_data;

    int total = 0;
    int bad = 0;
    int epoch = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    opc_top #(.WARP_W(WARP_W), .REG_W(REG_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_warp(req_warp),
        .req_reg(req_reg), .req_pos(req_pos), .req_pair(req_pair),
        .req_reuse(req_reuse), .warp_done(warp_done), .bank_rd_en(bank_rd_en),
        .bank0_rd_addr(bank0_rd_addr), .bank1_rd_addr(bank1_rd_addr),
        .bank0_rdata(bank0_rdata), .bank1_rdata(bank1_rdata),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data)
    );

    function automatic logic [DATA_W-1:0] mkval(input int ep, input logic b, input logic [ADDR_W-1:0] a);
        logic [7:0] e8;
        e8 = ep[7:0];
        return {e8, 13'd0, b, a};
    endfunction

    // bank model: synchronous read whose contents change with epoch
    always @(posedge clk) begin
        if (bank_rd_en[0]) bank0_rdata <= mkval(epoch, 1'b0, bank0_rd_addr);
        if (bank_rd_en[1]) bank1_rdata <= mkval(epoch, 1'b1, bank1_rd_addr);
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_req(input logic [2:0] w, input logic [7:0] r, input logic [1:0] p,
                           input logic pr, input logic ru, input logic [1:0] eh,
                           input int elo, input int ehi, input string tag);
        logic              lob;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        een;
        logic [63:0]       edata;
        @(negedge clk);
        req_valid = 1'b1; req_warp = w; req_reg = r; req_pos = p;
        req_pair = pr; req_reuse = ru;
        lob  = pr ? 1'b0 : r[0];
        addr = {w, r[7:1]};
        if (pr) een = ~eh;
        else    een = eh[0] ? 2'b00 : (lob ? 2'b10 : 2'b01);
        #1;
        check(bank_rd_en == een, {tag, " R2/R7 rd_en"}, 64'(bank_rd_en), 64'(een));
        if (een[0]) check(bank0_rd_addr == addr, {tag, " R2 addr0"}, 64'(bank0_rd_addr), 64'(addr));
        if (een[1]) check(bank1_rd_addr == addr, {tag, " R2 addr1"}, 64'(bank1_rd_addr), 64'(addr));
        @(negedge clk);
        edata = '0;
        edata[31:0] = mkval(elo, lob, addr);
        if (pr) edata[63:32] = mkval(ehi, 1'b1, addr);
        check(rsp_valid == 1'b1, {tag, " R11 rsp_valid"}, 64'(rsp_valid), 64'd1);
        check(rsp_hit == eh, {tag, " R3/R5 rsp_hit"}, 64'(rsp_hit), 64'(eh));
        check(rsp_data == edata, {tag, " R3/R8 rsp_data"}, rsp_data, edata);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0, "R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
        check(bank_rd_en == 2'b00, "R1 rd_en in reset", 64'(bank_rd_en), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R11 idle rsp_valid", 64'(rsp_valid), 64'd0);

        for (int i = 0; i < NV; i++) begin
            logic [32:0] v;
            v = VEC[i];
            epoch = i;
            run_req(v[32:30], v[29:22], v[21:20], v[19], v[18], v[17:16],
                    int'(v[15:8]), int'(v[7:0]), $sformatf("vec%0d", i));
        end

        // R11: no response without a request
        @(negedge clk);
        check(rsp_valid == 1'b0, "R11 no request no response", 64'(rsp_valid), 64'd0);

        // R9: re-hit held pair, then flush, then miss
        epoch = 30;
        run_req(3'd3, 8'd10, 2'd1, 1'b1, 1'b1, 2'b11, 19, 19, "pre-flush R9");
        @(negedge clk);
        warp_done = 1'b1;
        @(negedge clk);
        warp_done = 1'b0;
        epoch = 31;
        run_req(3'd3, 8'd10, 2'd1, 1'b1, 1'b0, 2'b00, 31, 31, "post-flush R9");

        // R1: reset empties slots
        epoch = 32;
        run_req(3'd0, 8'd2, 2'd2, 1'b0, 1'b1, 2'b00, 32, 0, "alloc R1");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        epoch = 33;
        run_req(3'd0, 8'd2, 2'd2, 1'b0, 1'b0, 2'b00, 33, 0, "after reset R1");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R11 actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule